// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-up to a usable state. Once reset is released on a stable clock, it holds the command bus in a no-operation state for a programmable wait (the 100 µs power-up settle time, given in clock cycles). It then closes every bank with a precharge-all, runs two auto-refresh cycles, and loads the mode register. After the mode-load settling time it raises a completion flag, which stays high until the next reset.

Every command and address output comes from a flop. A memory controller holds off its own traffic until the completion flag goes high and then takes over the command pins. The mode word is fixed at elaboration from parameters for burst length, burst type, read latency, operating mode and write burst mode. The command spacing after precharge, after each refresh and after the mode load is also set by parameters, in cycles. The timing parameters must be at least 2 and the address bus at least 11 bits wide.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, the outputs after each clock edge are COMMAND INHIBIT ({cs_n,ras_n,cas_n,we_n} = 1111), `sd_addr` = 0, `sd_ba` = 0 and `init_done` = 0.
- R2: In cycles 1 to WAIT_CYC after reset release (cycle n is the state after the n-th rising edge with `rst` low), the command is NOP (0111) with address and bank equal to 0.
- R3: In cycle WAIT_CYC+1 the command is PRECHARGE (0010) with `sd_addr[10]` = 1 (all banks), all other address bits 0 and `sd_ba` = 0.
- R4: The first AUTO REFRESH (0001) comes exactly T_RP cycles after the precharge. Every cycle between them is NOP.
- R5: The second AUTO REFRESH comes exactly T_RFC cycles after the first. Every cycle between them is NOP.
- R6: LOAD MODE REGISTER (0000) comes exactly T_RFC cycles after the second refresh, with `sd_ba` = 0. It is preceded by exactly two refreshes since reset.
- R7: The address during the mode load has this layout: bits [2:0] are the burst-length code (0:1, 1:2, 2:4, 3:8, 7:full page), bit 3 is the burst type (0 sequential, 1 interleaved), bits [6:4] are the CAS latency, bits [8:7] are the operating mode, bit 9 is the write burst mode (0 uses the programmed burst, 1 uses single-location writes), and all higher bits are 0.
- R8: `init_done` first goes high exactly T_MRD cycles after the mode load and is 0 in every earlier cycle. The cycles in between are NOP.
- R9: Once high, `init_done` stays high and the command stays NOP until reset.
- R10: A reset applied at any point in the sequence restarts it from R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (A10 flags all banks, mode word during load) |
| sd_ba | output | BA_W | Bank address |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench runs the sequence with reset pulses of random length, and reset is released again after a random number of cycles. This cuts the sequence off during the wait, inside each gap and after completion. It shows whether a restart really begins from a fresh wait (R10) or carries over counter or state residue. Directed runs cut reset exactly on the precharge, the first refresh, the mode load and the first completed cycle, then run one sequence well past completion. These runs separate off-by-one errors in each gap from each other, because a wrong gap moves every later command. The mode word is predicted arithmetically from field weights, so a swapped or shifted field shows up as a wrong address value during the load.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOAD_MODE = 4'b0000,
    CMD_REFRESH   = 4'b0001,
    CMD_PRECHG    = 4'b0010,
    CMD_NOP       = 4'b0111,
    CMD_INHIBIT   = 4'b1111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_RST,
    ST_WAIT,
    ST_PRE,
    ST_TRP,
    ST_REF1,
    ST_TRFC1,
    ST_REF2,
    ST_TRFC2,
    ST_LMR,
    ST_TMRD,
    ST_DONE
  } seq_state_e;

  localparam int MODE_BITS = 10;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Field order is what the memory decodes: BL, BT, CL, OP, WB from bit 0 up.
  function automatic logic [MODE_BITS-1:0] build_mode(
    input logic [2:0] bl, input logic bt, input logic [2:0] cl,
    input logic [1:0] op, input logic wb);
    return {wb, op, cl, bt, bl};
  endfunction

endpackage

// File: rtl/init_cycle_timer.sv
module init_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/init_step_fsm.sv
module init_step_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WAIT_CYC = 100,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 9,
  parameter int T_MRD    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_zero,
  output seq_state_e       st_nxt,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_dec
);

  localparam logic [CNT_W-1:0] LD_WAIT = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] LD_RFC  = CNT_W'(T_RFC - 2);
  localparam logic [CNT_W-1:0] LD_MRD  = CNT_W'(T_MRD - 2);

  seq_state_e st_q;

  always_comb begin
    st_nxt   = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    unique case (st_q)
      ST_RST: begin
        st_nxt   = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = LD_WAIT;
      end
      ST_WAIT: begin
        if (tmr_zero) st_nxt = ST_PRE;
        else          tmr_dec = 1'b1;
      end
      ST_PRE: begin
        st_nxt   = ST_TRP;
        tmr_load = 1'b1;
        tmr_val  = LD_RP;
      end
      ST_TRP: begin
        if (tmr_zero) st_nxt = ST_REF1;
        else          tmr_dec = 1'b1;
      end
      ST_REF1: begin
        st_nxt   = ST_TRFC1;
        tmr_load = 1'b1;
        tmr_val  = LD_RFC;
      end
      ST_TRFC1: begin
        if (tmr_zero) st_nxt = ST_REF2;
        else          tmr_dec = 1'b1;
      end
      ST_REF2: begin
        st_nxt   = ST_TRFC2;
        tmr_load = 1'b1;
        tmr_val  = LD_RFC;
      end
      ST_TRFC2: begin
        if (tmr_zero) st_nxt = ST_LMR;
        else          tmr_dec = 1'b1;
      end
      ST_LMR: begin
        st_nxt   = ST_TMRD;
        tmr_load = 1'b1;
        tmr_val  = LD_MRD;
      end
      ST_TMRD: begin
        if (tmr_zero) st_nxt = ST_DONE;
        else          tmr_dec = 1'b1;
      end
      ST_DONE: st_nxt = ST_DONE;
      default: st_nxt = ST_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RST;
    else     st_q <= st_nxt;
  end

endmodule

// File: rtl/init_cmd_encoder.sv
module init_cmd_encoder
  import sdram_init_pkg::*;
#(
  parameter int                   ADDR_W    = 13,
  parameter int                   BA_W      = 2,
  parameter logic [MODE_BITS-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        st_nxt,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              done
);

  localparam int A10 = 10;

  logic [ADDR_W-1:0] mode_ext;
  logic [ADDR_W-1:0] prechg_addr;

  // Widen the mode word and build the all-bank precharge pattern.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
    if (i < MODE_BITS) begin : g_mode
      assign mode_ext[i] = MODE_WORD[i];
    end else begin : g_pad
      assign mode_ext[i] = 1'b0;
    end
    assign prechg_addr[i] = (i == A10);
  end

  sdr_cmd_e          cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic              done_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    unique case (st_nxt)
      ST_RST:          cmd_d = CMD_INHIBIT;
      ST_PRE: begin
        cmd_d  = CMD_PRECHG;
        addr_d = prechg_addr;
      end
      ST_REF1, ST_REF2: cmd_d = CMD_REFRESH;
      ST_LMR: begin
        cmd_d  = CMD_LOAD_MODE;
        addr_d = mode_ext;
      end
      default:         cmd_d = CMD_NOP;
    endcase
    done_d = (st_nxt == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd  <= CMD_INHIBIT;
      addr <= '0;
      ba   <= '0;
      done <= 1'b0;
    end else begin
      cmd  <= cmd_d;
      addr <= addr_d;
      ba   <= '0;
      done <= done_d;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int         ADDR_W     = 13,
  parameter int         BA_W       = 2,
  parameter int         WAIT_CYC   = 13300,
  parameter int         T_RP       = 3,
  parameter int         T_RFC      = 9,
  parameter int         T_MRD      = 2,
  parameter logic [2:0] BURST_LEN  = 3'd3,
  parameter logic       BURST_TYPE = 1'b0,
  parameter logic [2:0] CAS_LAT    = 3'd3,
  parameter logic [1:0] OP_MODE    = 2'd0,
  parameter logic       WR_BURST   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done
);

  localparam int MAX_LD = max_of(max_of(WAIT_CYC, T_RP), max_of(T_RFC, T_MRD));
  localparam int CNT_W  = $clog2(MAX_LD + 1);
  localparam logic [MODE_BITS-1:0] MODE_WORD =
    build_mode(BURST_LEN, BURST_TYPE, CAS_LAT, OP_MODE, WR_BURST);

  seq_state_e       st_nxt;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_dec;
  logic             tmr_zero;
  logic [3:0]       cmd;

  init_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  init_step_fsm #(
    .CNT_W(CNT_W), .WAIT_CYC(WAIT_CYC), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tmr_zero (tmr_zero),
    .st_nxt   (st_nxt),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .tmr_dec  (tmr_dec)
  );

  init_cmd_encoder #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)
  ) u_enc (
    .clk    (clk),
    .rst    (rst),
    .st_nxt (st_nxt),
    .cmd    (cmd),
    .addr   (sd_addr),
    .ba     (sd_ba),
    .done   (init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int         ADDR_W     = 13,
  parameter int         BA_W       = 2,
  parameter int         WAIT_CYC   = 13300,
  parameter int         T_RP       = 3,
  parameter int         T_RFC      = 9,
  parameter int         T_MRD      = 2,
  parameter logic [2:0] BURST_LEN  = 3'd3,
  parameter logic       BURST_TYPE = 1'b0,
  parameter logic [2:0] CAS_LAT    = 3'd3,
  parameter logic [1:0] OP_MODE    = 2'd0,
  parameter logic       WR_BURST   = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BA_W-1:0]   sd_ba,
  input logic              init_done
);

  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  logic is_nop, is_pre, is_ref, is_lmr, is_cmd;
  assign is_nop = (c == 4'b0111);
  assign is_pre = (c == 4'b0010);
  assign is_ref = (c == 4'b0001);
  assign is_lmr = (c == 4'b0000);
  assign is_cmd = !sd_cs_n && !is_nop;

  logic [31:0] since_rst;
  logic [15:0] gap;
  logic [1:0]  ref_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      gap       <= '0;
      ref_cnt   <= '0;
    end else begin
      if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 1'b1;
      if (is_cmd)                     gap <= 16'd1;
      else if (gap != 16'hFFFF && gap != 16'd0) gap <= gap + 1'b1;
      if (is_ref && ref_cnt != 2'd3)  ref_cnt <= ref_cnt + 1'b1;
    end
  end

  // R3
  pre_time_chk: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> since_rst == 32'(WAIT_CYC + 1));

  // R3
  pre_allbank_chk: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (sd_addr[10] && (sd_addr & ~(ADDR_W'(1) << 10)) == '0 && sd_ba == '0));

  // R2
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 32'd0 && since_rst <= 32'(WAIT_CYC)) |-> is_nop);

  // R4 R5
  ref_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> ((ref_cnt == 2'd0 && gap == 16'(T_RP)) ||
                (ref_cnt == 2'd1 && gap == 16'(T_RFC))));

  // R6
  lmr_order_chk: assert property (@(posedge clk) disable iff (rst)
    is_lmr |-> (ref_cnt == 2'd2 && gap == 16'(T_RFC) && sd_ba == '0));

  // R7
  lmr_fields_chk: assert property (@(posedge clk) disable iff (rst)
    is_lmr |-> (sd_addr[2:0] == BURST_LEN && sd_addr[3] == BURST_TYPE &&
                sd_addr[6:4] == CAS_LAT && sd_addr[8:7] == OP_MODE &&
                sd_addr[9] == WR_BURST && (sd_addr >> 10) == '0));

  // R8
  done_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (gap == 16'(T_MRD) && ref_cnt == 2'd2));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .WAIT_CYC(WAIT_CYC), .T_RP(T_RP),
  .T_RFC(T_RFC), .T_MRD(T_MRD), .BURST_LEN(BURST_LEN),
  .BURST_TYPE(BURST_TYPE), .CAS_LAT(CAS_LAT), .OP_MODE(OP_MODE),
  .WR_BURST(WR_BURST)
) u_chk (
  .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
  .sd_ba(sd_ba), .init_done(init_done)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

  localparam int         ADDR_W = 13;
  localparam int         BA_W   = 2;
  localparam int         W      = 40;
  localparam int         TRP    = 3;
  localparam int         TRFC   = 7;
  localparam int         TMRD   = 2;
  localparam logic [2:0] BL     = 3'd3;
  localparam logic       BT     = 1'b1;
  localparam logic [2:0] CL     = 3'd2;
  localparam logic [1:0] OPM    = 2'd0;
  localparam logic       WB     = 1'b1;

  localparam int E_PRE  = W + 1;
  localparam int E_R1   = E_PRE + TRP;
  localparam int E_R2   = E_R1 + TRFC;
  localparam int E_LMR  = E_R2 + TRFC;
  localparam int E_DONE = E_LMR + TMRD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [ADDR_W-1:0] sd_addr;
  logic [BA_W-1:0]   sd_ba;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .WAIT_CYC(W), .T_RP(TRP), .T_RFC(TRFC),
    .T_MRD(TMRD), .BURST_LEN(BL), .BURST_TYPE(BT), .CAS_LAT(CL),
    .OP_MODE(OPM), .WR_BURST(WB)
  ) dut (
    .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .sd_ba(sd_ba), .init_done(init_done)
  );

  // R7: weights of each field in the mode word
  function automatic int mode_value();
    return int'(BL) + int'(BT) * 8 + int'(CL) * 16 + int'(OPM) * 128 + int'(WB) * 512;
  endfunction

  // Expected {cmd, addr, done} in cycle e after reset release (e = 0: in reset)
  function automatic logic [3:0] exp_cmd(int e);
    if (e == 0)       return 4'b1111;
    if (e == E_PRE)   return 4'b0010;
    if (e == E_R1 || e == E_R2) return 4'b0001;
    if (e == E_LMR)   return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic int exp_addr(int e);
    if (e == E_PRE) return 1024;
    if (e == E_LMR) return mode_value();
    return 0;
  endfunction

  function automatic string req_of(int e);
    if (e == 0)       return "R1";
    if (e <= W)       return "R2";
    if (e == E_PRE)   return "R3";
    if (e <= E_R1)    return "R4";
    if (e <= E_R2)    return "R5";
    if (e < E_LMR)    return "R6";
    if (e == E_LMR)   return "R6/R7";
    if (e <= E_DONE)  return "R8";
    return "R9";
  endfunction

  task automatic check_cycle(int e);
    logic [3:0] got_c;
    logic       exp_d;
    got_c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    exp_d = (e >= E_DONE);
    vectors++;
    if (got_c !== exp_cmd(e) || int'(sd_addr) != exp_addr(e) ||
        sd_ba !== '0 || init_done !== exp_d) begin
      errors++;
      $display("FAIL %s cycle %0d: cmd=%b addr=%0d ba=%0d done=%b expected cmd=%b addr=%0d ba=0 done=%b",
               req_of(e), e, got_c, sd_addr, sd_ba, init_done,
               exp_cmd(e), exp_addr(e), exp_d);
    end
  endtask

  // R1 R10: hold reset for n cycles, checking the reset outputs each time
  task automatic do_reset(int n);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_cycle(0);
    end
    rst = 1'b0;
  endtask

  // R2..R9: run len cycles after release, checking every one
  task automatic run_for(int len);
    for (int e = 1; e <= len; e++) begin
      @(posedge clk);
      @(negedge clk);
      check_cycle(e);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // Directed: full sequence well past completion (R1..R9)
    do_reset(3);
    run_for(E_DONE + 30);
    // Directed R10: restart cut exactly at each command and at completion
    do_reset(1); run_for(E_PRE);
    do_reset(2); run_for(E_R1);
    do_reset(1); run_for(E_LMR);
    do_reset(1); run_for(E_DONE);
    do_reset(1); run_for(E_DONE + 5);
    // Random cut points and reset lengths (R10)
    for (int k = 0; k < 40; k++) begin
      do_reset(int'($urandom_range(1, 4)));
      run_for(int'($urandom_range(1, E_DONE + 10)));
    end
    // Final complete run after random traffic
    do_reset(1);
    run_for(E_DONE + 10);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule